// File: doc/BRIEF.md
# Speculative L1 Word-State Tracker

This block keeps the per-word speculation state that sits beside a core's private L1 data cache when the core runs one thread of a speculatively parallelised loop. For each cache line it holds one modified bit. For each word it holds a safe-to-store bit, a safe-to-load bit, a stale-at-boundary bit, a came-from-a-peer bit and an invalid bit. On every local load or store it decides in the same cycle whether the central dependence table must hear about the access. The table's replies arrive as single-word requests: mark a word stale, invalidate a word, a successor read this word, or data for this word arrived from a peer cache. Each request takes effect at the next clock edge.

At a thread boundary the block computes the new invalid bits in one cycle. A normal start folds the stale marks into the invalid bits. A restart after a squash also folds in the peer-supplied words and the words of lines the squashed thread modified. A normal start is refused while any modified line is held. While the core's thread is speculative, the block refuses the write-back of a modified line; when the thread is non-speculative it lets the write-back go to L2.

Top module: `spec_word_tracker`

## Requirements
- R1: After reset every word reads invalid, and every modified, safe-to-store, safe-to-load, stale and peer bit reads 0. No start is blocked.
- R2: A store (accStore=1) to a word whose safe-to-store bit is 0 raises tableNotify with tableNotifyStore=1 in that cycle, and from the next edge on the line's modified bit and the word's safe-to-store bit read 1. This holds whether or not the thread is speculative.
- R3: A store to a word whose safe-to-store bit is 1 leaves tableNotify at 0. The bit is kept per word, so a neighbouring word of the same line still notifies.
- R4: A successor-read request (fwdReqValid) clears that word's safe-to-store bit. When it falls in the same cycle as a local store to the same word, the clear wins, so the next store notifies again.
- R5: A speculative load (isSpec=1, accStore=0) of a word whose safe-to-load bit is 0 raises tableNotify with tableNotifyStore=0 and sets the bit. A later load with the bit set does not notify. A load while isSpec=0 never notifies and leaves the bit at 0.
- R6: An eviction request for a modified line while isSpec=1 gives evictStall=1 and evictGrant=0, and the line stays modified. With isSpec=0 it is granted and the modified bit clears. A clean line is always granted.
- R7: A normal start (startReq=1, startSquash=0) while any line is modified gives startBlocked=1 and startAccept=0, and it changes no state.
- R8: An accepted start sets each word's invalid bit to its old value OR its stale bit, and clears the stale, safe-to-store, safe-to-load and peer bits of every word.
- R9: Peer data for a word (fwdDataValid) sets its peer bit and clears its invalid bit. A start with startSquash=1 also sets the invalid bit of every word whose peer bit was 1.
- R10: A start with startSquash=1 is accepted even when lines are modified. It clears every modified bit and sets the invalid bit of every word in those lines.
- R11: An invalidate request sets the invalid bit of the one addressed word only. A line fill (fillValid) clears the invalid bits of all words of that line.
- R12: A stale-mark request that falls in the same cycle as an accepted start survives the start: the word reads stale afterwards, and the following start invalidates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isSpec | input | 1 | Local thread is speculative |
| accValid | input | 1 | Local load or store this cycle |
| accStore | input | 1 | 1 = store, 0 = load |
| accLine | input | 6 | Line index of the access |
| accWord | input | 2 | Word index within the line |
| tableNotify | output | 1 | Access must be reported to the dependence table |
| tableNotifyStore | output | 1 | The report is for a store |
| fwdReqValid | input | 1 | A successor's read of a word was served from this cache |
| fwdReqLine | input | 6 | Line of that word |
| fwdReqWord | input | 2 | Word of that word |
| fwdDataValid | input | 1 | Word data arrived from a peer cache |
| fwdDataLine | input | 6 | Line of the arrived word |
| fwdDataWord | input | 2 | Word of the arrived word |
| flushMarkValid | input | 1 | Mark a word stale at the next boundary |
| flushMarkLine | input | 6 | Line to mark |
| flushMarkWord | input | 2 | Word to mark |
| invalMsgValid | input | 1 | Invalidate a word now |
| invalMsgLine | input | 6 | Line to invalidate |
| invalMsgWord | input | 2 | Word to invalidate |
| fillValid | input | 1 | Line filled from L2 |
| fillLine | input | 6 | Filled line |
| evictReq | input | 1 | Line must leave the cache |
| evictLine | input | 6 | Line to evict |
| evictGrant | output | 1 | Eviction may proceed (write-back if modified) |
| evictStall | output | 1 | Eviction refused; the core must wait |
| startReq | input | 1 | Begin a new thread on this core |
| startSquash | input | 1 | The start follows a squash |
| startAccept | output | 1 | Start takes effect at this edge |
| startBlocked | output | 1 | Normal start refused because lines are modified |
| probeLine | input | 6 | Line to observe |
| probeWord | input | 2 | Word to observe |
| probeInvalid | output | 1 | Invalid bit of the probed word |
| probeDirty | output | 1 | Modified bit of the probed line |
| probeSafeWrite | output | 1 | Safe-to-store bit of the probed word |
| probeSafeRead | output | 1 | Safe-to-load bit of the probed word |
| probeFlush | output | 1 | Stale bit of the probed word |
| probeFwd | output | 1 | Peer bit of the probed word |

## Verification
Two pairs of functions can land in one cycle on the same word. The first pair is a local store and a successor-read request: the store's report is decided from the old safe-to-store bit, and the clear must win. The bench drives both in one cycle on a word whose bit is set. It then checks that no report was raised, that the bit reads 0 afterwards, and that the next store reports again. The second pair is a stale mark and a thread start: the bench issues both in one cycle, then checks that the word reads stale but still valid, and that the next start invalidates it.

// File: rtl/spec_track_pkg.sv
package spec_track_pkg;

  // Qualified per-cycle actions handed from control to the state array.
  typedef struct packed {
    logic storeHit;   // local store updates line/word bits
    logic loadMark;   // speculative load sets safe-to-load
    logic fwdReq;     // successor read served: clear safe-to-store
    logic fwdData;    // peer data arrived
    logic flushMark;  // stale mark request
    logic invalMsg;   // invalidate request
    logic fill;       // line fill from L2
    logic evictClear; // write-back done: line no longer modified
    logic startAny;   // accepted thread start
    logic startSquash;// accepted start follows a squash
  } strobes_t;

endpackage

// File: rtl/spec_word_ctrl.sv
module spec_word_ctrl
  import spec_track_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     isSpec,
  input  logic     accValid,
  input  logic     accStore,
  input  logic     fwdReqValid,
  input  logic     fwdDataValid,
  input  logic     flushMarkValid,
  input  logic     invalMsgValid,
  input  logic     fillValid,
  input  logic     evictReq,
  input  logic     startReq,
  input  logic     startSquash,
  input  logic     accSafeWrite,
  input  logic     accSafeRead,
  input  logic     evictLineDirty,
  input  logic     anyDirty,
  output strobes_t strb,
  output logic     tableNotify,
  output logic     tableNotifyStore,
  output logic     evictGrant,
  output logic     evictStall,
  output logic     startAccept,
  output logic     startBlocked
);

  logic storeNeedsNote;
  logic loadNeedsNote;

  // Store reports when the word is not yet safe to store; load reports only
  // for a speculative thread that has not yet read the word.
  assign storeNeedsNote = accStore && !accSafeWrite;
  assign loadNeedsNote  = !accStore && isSpec && !accSafeRead;

  assign tableNotify      = accValid && (storeNeedsNote || loadNeedsNote);
  assign tableNotifyStore = accValid && accStore && !accSafeWrite;

  // Speculative modified lines may not reach L2.
  assign evictStall = evictReq && isSpec && evictLineDirty;
  assign evictGrant = evictReq && !evictStall;

  // Normal start waits for a clean cache; squash restart discards data.
  assign startAccept  = startReq && (startSquash || !anyDirty);
  assign startBlocked = startReq && !startAccept;

  always_comb begin
    strb             = '0;
    strb.storeHit    = accValid && accStore;
    strb.loadMark    = accValid && !accStore && isSpec;
    strb.fwdReq      = fwdReqValid;
    strb.fwdData     = fwdDataValid;
    strb.flushMark   = flushMarkValid;
    strb.invalMsg    = invalMsgValid;
    strb.fill        = fillValid;
    strb.evictClear  = evictGrant && evictLineDirty;
    strb.startAny    = startAccept;
    strb.startSquash = startAccept && startSquash;
  end

  // R5: a non-speculative load never reaches the table
  a_r5_nonspec_load_silent: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accStore && !isSpec) |-> !tableNotify);

  // R6: a granted eviction under speculation never carries modified data
  a_r6_spec_no_dirty_writeback: assert property (@(posedge clk) disable iff (!rstN)
    (evictGrant && isSpec) |-> !evictLineDirty);

  // R7: a normal start only proceeds with a clean cache
  a_r7_start_clean: assert property (@(posedge clk) disable iff (!rstN)
    (startAccept && !startSquash) |-> !anyDirty);

endmodule

// File: rtl/spec_word_state.sv
module spec_word_state
  import spec_track_pkg::*;
#(
  parameter int NUM_LINES      = 64,
  parameter int WORDS_PER_LINE = 4,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int WORD_W    = $clog2(WORDS_PER_LINE),
  localparam int NUM_WORDS = NUM_LINES * WORDS_PER_LINE
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [LINE_W-1:0] accLine,
  input  logic [WORD_W-1:0] accWord,
  input  logic [LINE_W-1:0] fwdReqLine,
  input  logic [WORD_W-1:0] fwdReqWord,
  input  logic [LINE_W-1:0] fwdDataLine,
  input  logic [WORD_W-1:0] fwdDataWord,
  input  logic [LINE_W-1:0] flushMarkLine,
  input  logic [WORD_W-1:0] flushMarkWord,
  input  logic [LINE_W-1:0] invalMsgLine,
  input  logic [WORD_W-1:0] invalMsgWord,
  input  logic [LINE_W-1:0] fillLine,
  input  logic [LINE_W-1:0] evictLine,
  input  logic [LINE_W-1:0] probeLine,
  input  logic [WORD_W-1:0] probeWord,
  output logic              accSafeWrite,
  output logic              accSafeRead,
  output logic              evictLineDirty,
  output logic              anyDirty,
  output logic              probeInvalid,
  output logic              probeDirty,
  output logic              probeSafeWrite,
  output logic              probeSafeRead,
  output logic              probeFlush,
  output logic              probeFwd
);

  logic [NUM_LINES-1:0] dirtyVec;
  logic [NUM_WORDS-1:0] invVec, swVec, srVec, flushVec, fwdVec;

  // Per-line modified bits
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic dirtyQ, dirtyD;
    logic storeHere;

    assign storeHere = strb.storeHit && (accLine == LINE_W'(l));

    always_comb begin
      dirtyD = dirtyQ;
      if (strb.startSquash) dirtyD = 1'b0;
      if (strb.evictClear && (evictLine == LINE_W'(l))) dirtyD = 1'b0;
      if (storeHere) dirtyD = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) dirtyQ <= 1'b0;
      else       dirtyQ <= dirtyD;
    end

    assign dirtyVec[l] = dirtyQ;
  end

  // Per-word speculation bits
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int LN = w / WORDS_PER_LINE;
    localparam int WN = w % WORDS_PER_LINE;

    logic invQ, swQ, srQ, flushQ, fwdQ;
    logic invD, swD, srD, flushD, fwdD;
    logic accHit, fwdReqHit, fwdDataHit, flushHit, invalHit, fillHit;

    assign accHit     = (accLine == LINE_W'(LN)) && (accWord == WORD_W'(WN));
    assign fwdReqHit  = strb.fwdReq && (fwdReqLine == LINE_W'(LN)) &&
                        (fwdReqWord == WORD_W'(WN));
    assign fwdDataHit = strb.fwdData && (fwdDataLine == LINE_W'(LN)) &&
                        (fwdDataWord == WORD_W'(WN));
    assign flushHit   = strb.flushMark && (flushMarkLine == LINE_W'(LN)) &&
                        (flushMarkWord == WORD_W'(WN));
    assign invalHit   = strb.invalMsg && (invalMsgLine == LINE_W'(LN)) &&
                        (invalMsgWord == WORD_W'(WN));
    assign fillHit    = strb.fill && (fillLine == LINE_W'(LN));

    always_comb begin
      invD   = invQ;
      swD    = swQ;
      srD    = srQ;
      flushD = flushQ;
      fwdD   = fwdQ;
      // Thread boundary: fold deferred invalidation, wipe speculation bits.
      if (strb.startAny) begin
        invD   = invQ | flushQ |
                 (strb.startSquash & (fwdQ | dirtyVec[LN]));
        swD    = 1'b0;
        srD    = 1'b0;
        flushD = 1'b0;
        fwdD   = 1'b0;
      end
      if (fillHit) invD = 1'b0;
      if (fwdDataHit) begin
        fwdD = 1'b1;
        invD = 1'b0;
      end
      if (invalHit) invD = 1'b1;
      if (flushHit) flushD = 1'b1;
      if (strb.storeHit && accHit) swD = 1'b1;
      if (strb.loadMark && accHit) srD = 1'b1;
      // Successor read wins over a same-cycle local store.
      if (fwdReqHit) swD = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        invQ   <= 1'b1;
        swQ    <= 1'b0;
        srQ    <= 1'b0;
        flushQ <= 1'b0;
        fwdQ   <= 1'b0;
      end else begin
        invQ   <= invD;
        swQ    <= swD;
        srQ    <= srD;
        flushQ <= flushD;
        fwdQ   <= fwdD;
      end
    end

    assign invVec[w]   = invQ;
    assign swVec[w]    = swQ;
    assign srVec[w]    = srQ;
    assign flushVec[w] = flushQ;
    assign fwdVec[w]   = fwdQ;

    // R8: a stale word is invalid after the start unless refilled that cycle
    a_r8_word_flush_invalidates: assert property (@(posedge clk) disable iff (!rstN)
      (strb.startAny && flushQ && !fillHit && !fwdDataHit) |=> invQ);

    // R4: a successor read leaves the word unsafe to store
    a_r4_fwdreq_clears_sw: assert property (@(posedge clk) disable iff (!rstN)
      (fwdReqHit) |=> !swQ);
  end

  assign accSafeWrite   = swVec[{accLine, accWord}];
  assign accSafeRead    = srVec[{accLine, accWord}];
  assign evictLineDirty = dirtyVec[evictLine];
  assign anyDirty       = |dirtyVec;

  assign probeInvalid   = invVec[{probeLine, probeWord}];
  assign probeDirty     = dirtyVec[probeLine];
  assign probeSafeWrite = swVec[{probeLine, probeWord}];
  assign probeSafeRead  = srVec[{probeLine, probeWord}];
  assign probeFlush     = flushVec[{probeLine, probeWord}];
  assign probeFwd       = fwdVec[{probeLine, probeWord}];

  // R8: an accepted start leaves no stale mark unless one arrives with it
  a_r8_flush_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strb.startAny && !strb.flushMark) |=> (flushVec == '0));

  // R8: an accepted start leaves no safe-to-load bit unless a load comes with it
  a_r8_sr_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strb.startAny && !strb.loadMark) |=> (srVec == '0));

  // R10: a squash restart discards every modified line
  a_r10_squash_drops_dirty: assert property (@(posedge clk) disable iff (!rstN)
    (strb.startSquash && !strb.storeHit) |=> !anyDirty);

endmodule

// File: rtl/spec_word_tracker.sv
module spec_word_tracker
  import spec_track_pkg::*;
#(
  parameter int NUM_LINES      = 64,
  parameter int WORDS_PER_LINE = 4,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int WORD_W = $clog2(WORDS_PER_LINE)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              isSpec,
  input  logic              accValid,
  input  logic              accStore,
  input  logic [LINE_W-1:0] accLine,
  input  logic [WORD_W-1:0] accWord,
  output logic              tableNotify,
  output logic              tableNotifyStore,
  input  logic              fwdReqValid,
  input  logic [LINE_W-1:0] fwdReqLine,
  input  logic [WORD_W-1:0] fwdReqWord,
  input  logic              fwdDataValid,
  input  logic [LINE_W-1:0] fwdDataLine,
  input  logic [WORD_W-1:0] fwdDataWord,
  input  logic              flushMarkValid,
  input  logic [LINE_W-1:0] flushMarkLine,
  input  logic [WORD_W-1:0] flushMarkWord,
  input  logic              invalMsgValid,
  input  logic [LINE_W-1:0] invalMsgLine,
  input  logic [WORD_W-1:0] invalMsgWord,
  input  logic              fillValid,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              evictReq,
  input  logic [LINE_W-1:0] evictLine,
  output logic              evictGrant,
  output logic              evictStall,
  input  logic              startReq,
  input  logic              startSquash,
  output logic              startAccept,
  output logic              startBlocked,
  input  logic [LINE_W-1:0] probeLine,
  input  logic [WORD_W-1:0] probeWord,
  output logic              probeInvalid,
  output logic              probeDirty,
  output logic              probeSafeWrite,
  output logic              probeSafeRead,
  output logic              probeFlush,
  output logic              probeFwd
);

  strobes_t strb;
  logic     accSafeWrite, accSafeRead, evictLineDirty, anyDirty;

  spec_word_ctrl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .isSpec          (isSpec),
    .accValid        (accValid),
    .accStore        (accStore),
    .fwdReqValid     (fwdReqValid),
    .fwdDataValid    (fwdDataValid),
    .flushMarkValid  (flushMarkValid),
    .invalMsgValid   (invalMsgValid),
    .fillValid       (fillValid),
    .evictReq        (evictReq),
    .startReq        (startReq),
    .startSquash     (startSquash),
    .accSafeWrite    (accSafeWrite),
    .accSafeRead     (accSafeRead),
    .evictLineDirty  (evictLineDirty),
    .anyDirty        (anyDirty),
    .strb            (strb),
    .tableNotify     (tableNotify),
    .tableNotifyStore(tableNotifyStore),
    .evictGrant      (evictGrant),
    .evictStall      (evictStall),
    .startAccept     (startAccept),
    .startBlocked    (startBlocked)
  );

  spec_word_state #(
    .NUM_LINES      (NUM_LINES),
    .WORDS_PER_LINE (WORDS_PER_LINE)
  ) u_state (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .accLine        (accLine),
    .accWord        (accWord),
    .fwdReqLine     (fwdReqLine),
    .fwdReqWord     (fwdReqWord),
    .fwdDataLine    (fwdDataLine),
    .fwdDataWord    (fwdDataWord),
    .flushMarkLine  (flushMarkLine),
    .flushMarkWord  (flushMarkWord),
    .invalMsgLine   (invalMsgLine),
    .invalMsgWord   (invalMsgWord),
    .fillLine       (fillLine),
    .evictLine      (evictLine),
    .probeLine      (probeLine),
    .probeWord      (probeWord),
    .accSafeWrite   (accSafeWrite),
    .accSafeRead    (accSafeRead),
    .evictLineDirty (evictLineDirty),
    .anyDirty       (anyDirty),
    .probeInvalid   (probeInvalid),
    .probeDirty     (probeDirty),
    .probeSafeWrite (probeSafeWrite),
    .probeSafeRead  (probeSafeRead),
    .probeFlush     (probeFlush),
    .probeFwd       (probeFwd)
  );

endmodule

// File: tb/spec_word_tracker_tb.sv
module spec_word_tracker_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isSpec = 1'b0;
  logic accValid = 1'b0, accStore = 1'b0;
  logic [5:0] accLine = '0;
  logic [1:0] accWord = '0;
  logic tableNotify, tableNotifyStore;
  logic fwdReqValid = 1'b0;
  logic [5:0] fwdReqLine = '0;
  logic [1:0] fwdReqWord = '0;
  logic fwdDataValid = 1'b0;
  logic [5:0] fwdDataLine = '0;
  logic [1:0] fwdDataWord = '0;
  logic flushMarkValid = 1'b0;
  logic [5:0] flushMarkLine = '0;
  logic [1:0] flushMarkWord = '0;
  logic invalMsgValid = 1'b0;
  logic [5:0] invalMsgLine = '0;
  logic [1:0] invalMsgWord = '0;
  logic fillValid = 1'b0;
  logic [5:0] fillLine = '0;
  logic evictReq = 1'b0;
  logic [5:0] evictLine = '0;
  logic evictGrant, evictStall;
  logic startReq = 1'b0, startSquash = 1'b0;
  logic startAccept, startBlocked;
  logic [5:0] probeLine = '0;
  logic [1:0] probeWord = '0;
  logic probeInvalid, probeDirty, probeSafeWrite, probeSafeRead, probeFlush, probeFwd;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  spec_word_tracker u_dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic probe(input logic [5:0] l, input logic [1:0] w);
    probeLine = l;
    probeWord = w;
    #1;
  endtask

  // One local access; notify outputs checked in the access cycle.
  task automatic access(input logic st, input logic [5:0] l, input logic [1:0] w,
                        input logic expNote, input string req);
    @(negedge clk);
    accValid = 1'b1; accStore = st; accLine = l; accWord = w;
    #1;
    chk({req, " notify"}, tableNotify, expNote);
    if (expNote) chk({req, " notify kind"}, tableNotifyStore, st);
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic fill(input logic [5:0] l);
    @(negedge clk);
    fillValid = 1'b1; fillLine = l;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doStart(input logic squash, input logic expAcc, input string req);
    @(negedge clk);
    startReq = 1'b1; startSquash = squash;
    #1;
    chk({req, " startAccept"}, startAccept, expAcc);
    chk({req, " startBlocked"}, startBlocked, !expAcc);
    @(negedge clk);
    startReq = 1'b0; startSquash = 1'b0;
  endtask

  task automatic t_reset;
    probe(6'd0, 2'd0);
    chk("R1 invalid", probeInvalid, 1'b1);
    chk("R1 dirty", probeDirty, 1'b0);
    chk("R1 sw", probeSafeWrite, 1'b0);
    chk("R1 sr", probeSafeRead, 1'b0);
    chk("R1 flush", probeFlush, 1'b0);
    chk("R1 fwd", probeFwd, 1'b0);
    chk("R1 startBlocked", startBlocked, 1'b0);
  endtask

  task automatic t_store;
    isSpec = 1'b1;
    access(1'b1, 6'd3, 2'd2, 1'b1, "R2 first store");
    probe(6'd3, 2'd2);
    chk("R2 dirty set", probeDirty, 1'b1);
    chk("R2 sw set", probeSafeWrite, 1'b1);
    access(1'b1, 6'd3, 2'd2, 1'b0, "R3 repeat store");
    probe(6'd3, 2'd3);
    chk("R3 neighbour sw", probeSafeWrite, 1'b0);
    access(1'b1, 6'd3, 2'd3, 1'b1, "R3 neighbour store");
  endtask

  task automatic t_fwdreq;
    @(negedge clk);
    fwdReqValid = 1'b1; fwdReqLine = 6'd3; fwdReqWord = 2'd2;
    @(negedge clk);
    fwdReqValid = 1'b0;
    probe(6'd3, 2'd2);
    chk("R4 sw cleared", probeSafeWrite, 1'b0);
    access(1'b1, 6'd3, 2'd2, 1'b1, "R2 store after clear");
    // collision: store and successor read on the same word
    @(negedge clk);
    accValid = 1'b1; accStore = 1'b1; accLine = 6'd3; accWord = 2'd2;
    fwdReqValid = 1'b1; fwdReqLine = 6'd3; fwdReqWord = 2'd2;
    #1;
    chk("R4 collision notify", tableNotify, 1'b0);
    @(negedge clk);
    accValid = 1'b0; fwdReqValid = 1'b0;
    probe(6'd3, 2'd2);
    chk("R4 collision clear wins", probeSafeWrite, 1'b0);
    access(1'b1, 6'd3, 2'd2, 1'b1, "R4 store after collision");
  endtask

  task automatic t_load;
    isSpec = 1'b1;
    access(1'b0, 6'd10, 2'd0, 1'b1, "R5 first spec load");
    probe(6'd10, 2'd0);
    chk("R5 sr set", probeSafeRead, 1'b1);
    access(1'b0, 6'd10, 2'd0, 1'b0, "R5 repeat load");
    isSpec = 1'b0;
    access(1'b0, 6'd11, 2'd1, 1'b0, "R5 nonspec load");
    probe(6'd11, 2'd1);
    chk("R5 nonspec sr", probeSafeRead, 1'b0);
  endtask

  task automatic t_evict;
    isSpec = 1'b1;
    @(negedge clk);
    evictReq = 1'b1; evictLine = 6'd3;
    #1;
    chk("R6 spec stall", evictStall, 1'b1);
    chk("R6 spec grant", evictGrant, 1'b0);
    evictLine = 6'd20;
    #1;
    chk("R6 clean grant", evictGrant, 1'b1);
    @(negedge clk);
    evictReq = 1'b0;
    probe(6'd3, 2'd0);
    chk("R6 still dirty", probeDirty, 1'b1);
    isSpec = 1'b0;
    @(negedge clk);
    evictReq = 1'b1; evictLine = 6'd3;
    #1;
    chk("R6 nonspec grant", evictGrant, 1'b1);
    @(negedge clk);
    evictReq = 1'b0;
    probe(6'd3, 2'd0);
    chk("R6 dirty cleared", probeDirty, 1'b0);
  endtask

  task automatic t_blocked;
    isSpec = 1'b0;
    access(1'b1, 6'd4, 2'd0, 1'b1, "R2 nonspec store");
    doStart(1'b0, 1'b0, "R7 blocked");
    probe(6'd4, 2'd0);
    chk("R7 sw kept", probeSafeWrite, 1'b1);
    probe(6'd10, 2'd0);
    chk("R7 sr kept", probeSafeRead, 1'b1);
    @(negedge clk);
    evictReq = 1'b1; evictLine = 6'd4;
    @(negedge clk);
    evictReq = 1'b0;
    doStart(1'b0, 1'b1, "R7 clean start");
    probe(6'd4, 2'd0);
    chk("R8 sw wiped", probeSafeWrite, 1'b0);
    probe(6'd10, 2'd0);
    chk("R8 sr wiped", probeSafeRead, 1'b0);
  endtask

  task automatic t_flush;
    fill(6'd5);
    probe(6'd5, 2'd1);
    chk("R11 fill valid", probeInvalid, 1'b0);
    @(negedge clk);
    flushMarkValid = 1'b1; flushMarkLine = 6'd5; flushMarkWord = 2'd1;
    @(negedge clk);
    flushMarkValid = 1'b0;
    probe(6'd5, 2'd1);
    chk("R8 flush marked", probeFlush, 1'b1);
    chk("R8 valid before start", probeInvalid, 1'b0);
    doStart(1'b0, 1'b1, "R8 start");
    probe(6'd5, 2'd1);
    chk("R8 flushed word invalid", probeInvalid, 1'b1);
    chk("R8 flush cleared", probeFlush, 1'b0);
    probe(6'd5, 2'd0);
    chk("R8 other word valid", probeInvalid, 1'b0);
  endtask

  task automatic t_forward;
    @(negedge clk);
    fwdDataValid = 1'b1; fwdDataLine = 6'd6; fwdDataWord = 2'd2;
    @(negedge clk);
    fwdDataValid = 1'b0;
    probe(6'd6, 2'd2);
    chk("R9 fwd set", probeFwd, 1'b1);
    chk("R9 word valid", probeInvalid, 1'b0);
    doStart(1'b0, 1'b1, "R9 normal start");
    probe(6'd6, 2'd2);
    chk("R9 normal start keeps valid", probeInvalid, 1'b0);
    chk("R8 fwd cleared", probeFwd, 1'b0);
    @(negedge clk);
    fwdDataValid = 1'b1; fwdDataLine = 6'd6; fwdDataWord = 2'd3;
    @(negedge clk);
    fwdDataValid = 1'b0;
    doStart(1'b1, 1'b1, "R9 squash start");
    probe(6'd6, 2'd3);
    chk("R9 squash invalidates fwd", probeInvalid, 1'b1);
    probe(6'd6, 2'd2);
    chk("R9 untouched word valid", probeInvalid, 1'b0);
  endtask

  task automatic t_squash;
    isSpec = 1'b1;
    fill(6'd7);
    access(1'b1, 6'd7, 2'd0, 1'b1, "R10 spec store");
    doStart(1'b1, 1'b1, "R10 squash with dirty");
    probe(6'd7, 2'd0);
    chk("R10 dirty dropped", probeDirty, 1'b0);
    chk("R10 word0 invalid", probeInvalid, 1'b1);
    probe(6'd7, 2'd3);
    chk("R10 word3 invalid", probeInvalid, 1'b1);
  endtask

  task automatic t_inval;
    fill(6'd8);
    @(negedge clk);
    invalMsgValid = 1'b1; invalMsgLine = 6'd8; invalMsgWord = 2'd2;
    @(negedge clk);
    invalMsgValid = 1'b0;
    probe(6'd8, 2'd2);
    chk("R11 word invalid", probeInvalid, 1'b1);
    probe(6'd8, 2'd1);
    chk("R11 neighbour valid", probeInvalid, 1'b0);
  endtask

  task automatic t_flushStart;
    fill(6'd9);
    @(negedge clk);
    flushMarkValid = 1'b1; flushMarkLine = 6'd9; flushMarkWord = 2'd0;
    startReq = 1'b1; startSquash = 1'b0;
    #1;
    chk("R12 start accepted", startAccept, 1'b1);
    @(negedge clk);
    flushMarkValid = 1'b0; startReq = 1'b0;
    probe(6'd9, 2'd0);
    chk("R12 mark survives", probeFlush, 1'b1);
    chk("R12 still valid", probeInvalid, 1'b0);
    doStart(1'b0, 1'b1, "R12 next start");
    probe(6'd9, 2'd0);
    chk("R12 invalid after next start", probeInvalid, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_store();
    t_fwdreq();
    t_load();
    t_evict();
    t_blocked();
    t_flush();
    t_forward();
    t_squash();
    t_inval();
    t_flushStart();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule